// File: doc/BRIEF.md
# Dual-Rate Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port that sends and receives NRZ characters on two separate lines. Each character is framed by one low start bit and one high stop bit, carries its data least significant bit first, and holds either eight or nine data bits. In nine-bit mode the extra bit is supplied with the transmit write and returned beside the received byte.

The transmitter and the receiver each have their own bit-rate generator. Both generators share one coarse prescaler. Each then applies its own power-of-two divider and its own optional 8-bit extended divider, so the two directions can run at different rates. The receiver oversamples the line sixteen times per bit and decides each bit by a two-of-three majority vote near the middle of the bit. A status byte reports the state of the transmit buffer, the receive buffer, overrun and line idle. A single interrupt output combines four status conditions, each behind its own enable.

Top module: `uart_dual_rate`

## Requirements
- R1: After reset, status reads C0h (transmit empty and transmit complete set, all other bits clear), txd is high and irq is low while all enables are low.
- R2: A transmitted frame is one low start bit, then the data bits LSB first, then one high stop bit. There are 8 data bits when word9 is 0. When word9 is 1 there are 9, the ninth taken from tx_bit8 as sampled at the write. Between frames txd is high.
- R3: Every bit lasts 16*P clock cycles, where P = 2 * A * 2^D * E. A is 1, 3, 4 or 13 for cfg_pre codes 0, 1, 2 and 3. D is the direction's divider code. E is the direction's extended divider, with 0 counting as 1.
- R4: Status bit 7 (transmit empty) clears on an accepted tx_wr and sets when the buffered word moves into the shifter. A tx_wr while bit 7 is clear is ignored. Status bit 6 (transmit complete) clears on an accepted write and sets at the end of a stop bit when no word is waiting.
- R5: The receiver counts the start-detect sample as sample 1 and decides on the majority of samples 8, 9 and 10. A low pulse that does not hold a majority at mid start bit starts no character.
- R6: A received character is presented on rx_data, and in nine-bit mode its ninth bit on rx_bit8. Status bit 5 (receive full) is set when the character completes at mid stop bit.
- R7: If a character completes while status bit 5 is set, status bit 3 (overrun) is set, the new character is discarded and rx_data keeps the old one.
- R8: After a received character, status bit 4 (idle) sets once the line has stayed high for a full frame time (160 samples for 8-bit words, 176 for 9-bit words).
- R9: A cfg_wr while tx_en or rx_en is high leaves the rate settings unchanged.
- R10: irq is high exactly when an enabled condition holds: ie_txe with bit 7, ie_txc with bit 6, ie_rxf with bit 5 or bit 3, ie_idle with bit 4.
- R11: A pulse on rx_rd clears status bits 5, 4 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load the rate settings below (only while both directions are disabled) |
| cfg_pre | input | 2 | Shared coarse prescaler code |
| cfg_tx_div | input | DIV_W | Transmit power-of-two divider code |
| cfg_rx_div | input | DIV_W | Receive power-of-two divider code |
| cfg_tx_ext | input | EXT_W | Transmit extended divider, 0 = unused |
| cfg_rx_ext | input | EXT_W | Receive extended divider, 0 = unused |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| word9 | input | 1 | 1 selects 9-bit words |
| tx_wr | input | 1 | Write one word into the transmit buffer |
| tx_data | input | 8 | Transmit byte |
| tx_bit8 | input | 1 | Ninth transmit bit |
| rx_rd | input | 1 | Acknowledge the received word and clear receive flags |
| rx_data | output | 8 | Last accepted received byte |
| rx_bit8 | output | 1 | Ninth bit of the last accepted 9-bit word |
| ie_txe | input | 1 | Interrupt enable for transmit empty |
| ie_txc | input | 1 | Interrupt enable for transmit complete |
| ie_rxf | input | 1 | Interrupt enable for receive full and overrun |
| ie_idle | input | 1 | Interrupt enable for line idle |
| status | output | 8 | {txempty, txdone, rxfull, idle, overrun, 3'b000} |
| irq | output | 1 | Combined interrupt request |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The assertions assume that a rate setting is only ever written while both directions are disabled, so that the checks on the frozen period are not broken by a legal reconfiguration. They also assume that rx_rd is never pulsed in the same cycle that a character completes. The bench keeps within these limits by changing the configuration only after lowering both enables, and by reading a character only after it has seen receive-full. In the overrun case it waits until the transmitter reports completion before it reads.

// File: rtl/uart_dr_pkg.sv
package uart_dr_pkg;

  // status byte bit positions
  localparam int ST_TXE  = 7;
  localparam int ST_TXC  = 6;
  localparam int ST_RXF  = 5;
  localparam int ST_IDLE = 4;
  localparam int ST_OVR  = 3;

  // oversampling ratio and the samples used for the vote
  localparam int OVS     = 16;
  localparam int VOTE_A  = 8;
  localparam int VOTE_B  = 9;
  localparam int VOTE_C  = 10;

  // coarse prescaler factor for each code
  function automatic int unsigned coarse_factor(input int unsigned code);
    case (code)
      0: return 1;
      1: return 3;
      2: return 4;
      default: return 13;
    endcase
  endfunction

  // clock cycles per oversampling tick
  function automatic int unsigned tick_period(input int unsigned pre_code,
                                              input int unsigned div_code,
                                              input int unsigned ext);
    int unsigned e;
    e = (ext == 0) ? 1 : ext;
    return 2 * coarse_factor(pre_code) * (32'd1 << div_code) * e;
  endfunction

  // samples per frame used for the idle timeout
  function automatic int unsigned frame_samples(input logic nine);
    return nine ? 11 * OVS : 10 * OVS;
  endfunction

endpackage

// File: rtl/uart_dr_rategen.sv
module uart_dr_rategen #(
  parameter int PER_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || restart) begin
      cnt <= period - PER_W'(1);
    end else if (cnt == '0) begin
      cnt <= period - PER_W'(1);
    end else begin
      cnt <= cnt - PER_W'(1);
    end
  end

  assign tick = run && !restart && (cnt == '0);
endmodule

// File: rtl/uart_dr_tx.sv
module uart_dr_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       word9,
  input  logic       wr,
  input  logic [7:0] data,
  input  logic       bit8,
  output logic       txd,
  output logic       tx_empty,
  output logic       tx_done,
  output logic       busy,
  output logic       load
);
  import uart_dr_pkg::*;
  localparam int FW = 11;

  logic          full;
  logic [7:0]    hold;
  logic          hold8;
  logic [FW-1:0] shreg;
  logic [3:0]    bitc;
  logic [3:0]    tcnt;
  logic [3:0]    last;
  logic          wr_ok;

  assign wr_ok = wr && !full;
  assign load  = en && !busy && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      hold    <= '0;
      hold8   <= 1'b0;
      busy    <= 1'b0;
      shreg   <= '1;
      bitc    <= '0;
      tcnt    <= '0;
      last    <= 4'd9;
      tx_done <= 1'b1;
    end else begin
      if (wr_ok) begin
        full    <= 1'b1;
        hold    <= data;
        hold8   <= bit8;
        tx_done <= 1'b0;
      end
      if (load) begin
        full  <= 1'b0;
        busy  <= 1'b1;
        shreg <= word9 ? {1'b1, hold8, hold, 1'b0} : {2'b11, hold, 1'b0};
        bitc  <= '0;
        tcnt  <= '0;
        last  <= word9 ? 4'd10 : 4'd9;
      end else if (busy && tick) begin
        if (tcnt == 4'(OVS - 1)) begin
          tcnt  <= '0;
          shreg <= {1'b1, shreg[FW-1:1]};
          bitc  <= bitc + 4'd1;
          if (bitc == last) begin
            busy <= 1'b0;
            if (!wr_ok) tx_done <= !full;
          end
        end else begin
          tcnt <= tcnt + 4'd1;
        end
      end
    end
  end

  assign tx_empty = !full;
  assign txd      = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/uart_dr_rx.sv
module uart_dr_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       tick,
  input  logic       rxd,
  input  logic       word9,
  input  logic       rd,
  output logic [7:0] data,
  output logic       bit8,
  output logic       full,
  output logic       ovr,
  output logic       idle,
  output logic       done
);
  import uart_dr_pkg::*;

  logic [1:0] sync;
  logic       rxs;
  logic       active;
  logic [3:0] scnt;
  logic [4:0] cur;
  logic [3:0] bidx;
  logic [3:0] last;
  logic       s_a, s_b, maj, vote;
  logic [8:0] sh;
  logic       armed;
  logic [7:0] icnt;
  logic [7:0] itarget;

  assign rxs     = sync[1];
  assign cur     = {1'b0, scnt} + 5'd1;
  assign maj     = (s_a & s_b) | (s_a & rxs) | (s_b & rxs);
  assign last    = word9 ? 4'd10 : 4'd9;
  assign vote    = en && active && tick && (cur == 5'(VOTE_C));
  assign done    = vote && (bidx == last);
  assign itarget = 8'(frame_samples(word9));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync   <= 2'b11;
      active <= 1'b0;
      scnt   <= '0;
      bidx   <= '0;
      s_a    <= 1'b1;
      s_b    <= 1'b1;
      sh     <= '0;
      data   <= '0;
      bit8   <= 1'b0;
      full   <= 1'b0;
      ovr    <= 1'b0;
      idle   <= 1'b0;
      armed  <= 1'b0;
      icnt   <= '0;
    end else begin
      sync <= {sync[0], rxd};
      if (rd) begin
        full <= 1'b0;
        ovr  <= 1'b0;
        idle <= 1'b0;
      end
      if (!en) begin
        active <= 1'b0;
      end else if (tick) begin
        if (!active) begin
          if (!rxs) begin
            active <= 1'b1;
            scnt   <= 4'd1;
            bidx   <= '0;
            icnt   <= '0;
          end else if (armed) begin
            if (icnt + 8'd1 == itarget) begin
              idle  <= 1'b1;
              armed <= 1'b0;
              icnt  <= '0;
            end else begin
              icnt <= icnt + 8'd1;
            end
          end
        end else begin
          if (cur == 5'(VOTE_A)) s_a <= rxs;
          if (cur == 5'(VOTE_B)) s_b <= rxs;
          if (cur == 5'(VOTE_C)) begin
            if (bidx == 4'd0) begin
              if (maj) active <= 1'b0;
            end else if (bidx == last) begin
              active <= 1'b0;
              armed  <= 1'b1;
              icnt   <= '0;
            end else begin
              sh <= {maj, sh[8:1]};
            end
          end
          if (cur == 5'(OVS)) begin
            scnt <= '0;
            bidx <= bidx + 4'd1;
          end else begin
            scnt <= cur[3:0];
          end
        end
      end
      if (done) begin
        if (full) begin
          ovr <= 1'b1;
        end else begin
          full <= 1'b1;
          data <= word9 ? sh[7:0] : sh[8:1];
          if (word9) bit8 <= sh[8];
        end
      end
    end
  end
endmodule

// File: rtl/uart_dual_rate.sv
module uart_dual_rate #(
  parameter int DIV_W = 3,
  parameter int EXT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_pre,
  input  logic [DIV_W-1:0] cfg_tx_div,
  input  logic [DIV_W-1:0] cfg_rx_div,
  input  logic [EXT_W-1:0] cfg_tx_ext,
  input  logic [EXT_W-1:0] cfg_rx_ext,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             word9,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  input  logic             tx_bit8,
  input  logic             rx_rd,
  output logic [7:0]       rx_data,
  output logic             rx_bit8,
  input  logic             ie_txe,
  input  logic             ie_txc,
  input  logic             ie_rxf,
  input  logic             ie_idle,
  output logic [7:0]       status,
  output logic             irq,
  input  logic             rxd,
  output logic             txd
);
  import uart_dr_pkg::*;

  // 1 for the doubling, 4 for the largest coarse factor, then the two dividers
  localparam int PER_W = 1 + 4 + (2 ** DIV_W - 1) + EXT_W;

  logic [1:0]       pre_q;
  logic [DIV_W-1:0] tdiv_q, rdiv_q;
  logic [EXT_W-1:0] text_q, rext_q;
  logic [PER_W-1:0] tx_period, rx_period;
  logic             tx_tick, rx_tick;
  logic             tx_busy, tx_load, tx_empty, tx_done;
  logic             rx_full, rx_ovr, rx_idle, rx_done;
  logic             cfg_ok;

  assign cfg_ok = cfg_wr && !tx_en && !rx_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tdiv_q <= '0;
      rdiv_q <= '0;
      text_q <= '0;
      rext_q <= '0;
    end else if (cfg_ok) begin
      pre_q  <= cfg_pre;
      tdiv_q <= cfg_tx_div;
      rdiv_q <= cfg_rx_div;
      text_q <= cfg_tx_ext;
      rext_q <= cfg_rx_ext;
    end
  end

  assign tx_period = PER_W'(tick_period(32'(pre_q), 32'(tdiv_q), 32'(text_q)));
  assign rx_period = PER_W'(tick_period(32'(pre_q), 32'(rdiv_q), 32'(rext_q)));

  uart_dr_rategen #(.PER_W(PER_W)) u_tx_rate (
    .clk(clk), .rst_n(rst_n), .run(tx_en || tx_busy), .restart(tx_load),
    .period(tx_period), .tick(tx_tick)
  );

  uart_dr_rategen #(.PER_W(PER_W)) u_rx_rate (
    .clk(clk), .rst_n(rst_n), .run(rx_en), .restart(1'b0),
    .period(rx_period), .tick(rx_tick)
  );

  uart_dr_tx u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .tick(tx_tick), .word9(word9),
    .wr(tx_wr), .data(tx_data), .bit8(tx_bit8), .txd(txd),
    .tx_empty(tx_empty), .tx_done(tx_done), .busy(tx_busy), .load(tx_load)
  );

  uart_dr_rx u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(rx_tick), .rxd(rxd),
    .word9(word9), .rd(rx_rd), .data(rx_data), .bit8(rx_bit8),
    .full(rx_full), .ovr(rx_ovr), .idle(rx_idle), .done(rx_done)
  );

  always_comb begin
    status          = '0;
    status[ST_TXE]  = tx_empty;
    status[ST_TXC]  = tx_done;
    status[ST_RXF]  = rx_full;
    status[ST_IDLE] = rx_idle;
    status[ST_OVR]  = rx_ovr;
  end

  assign irq = (ie_txe && tx_empty) || (ie_txc && tx_done) ||
               (ie_rxf && (rx_full || rx_ovr)) || (ie_idle && rx_idle);
endmodule

// File: rtl/uart_dual_rate_chk.sv
module uart_dual_rate_chk #(
  parameter int PER_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_en,
  input logic             rx_en,
  input logic [7:0]       status,
  input logic             irq,
  input logic             txd,
  input logic             ie_txe,
  input logic             ie_txc,
  input logic             ie_rxf,
  input logic             ie_idle,
  input logic             tx_busy,
  input logic             rx_done,
  input logic [PER_W-1:0] tx_period,
  input logic [PER_W-1:0] rx_period
);
  logic any_en;
  assign any_en = tx_en || rx_en;

  a_r4_tc_implies_tdre: assert property (@(posedge clk) disable iff (!rst_n)
    status[6] |-> status[7]);

  a_r2_line_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  a_r7_ovr_with_rdrf: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |-> status[5]);

  a_r9_rate_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (any_en && $past(any_en)) |-> ($stable(tx_period) && $stable(rx_period)));

  a_r6_rdrf_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> $past(rx_done));

  a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_txe && !ie_txc && !ie_rxf && !ie_idle) |-> !irq);
endmodule

bind uart_dual_rate uart_dual_rate_chk #(.PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .status(status),
  .irq(irq), .txd(txd), .ie_txe(ie_txe), .ie_txc(ie_txc), .ie_rxf(ie_rxf),
  .ie_idle(ie_idle), .tx_busy(tx_busy), .rx_done(rx_done),
  .tx_period(tx_period), .rx_period(rx_period)
);

// File: tb/uart_dual_rate_test.sv
module uart_dual_rate_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_pre = '0;
  logic [2:0] cfg_tx_div = '0, cfg_rx_div = '0;
  logic [7:0] cfg_tx_ext = '0, cfg_rx_ext = '0;
  logic       tx_en = 1'b0, rx_en = 1'b0, word9 = 1'b0;
  logic       tx_wr = 1'b0, tx_bit8 = 1'b0, rx_rd = 1'b0;
  logic [7:0] tx_data = '0;
  logic [7:0] rx_data;
  logic       rx_bit8;
  logic       ie_txe = 1'b0, ie_txc = 1'b0, ie_rxf = 1'b0, ie_idle = 1'b0;
  logic [7:0] status;
  logic       irq, txd, rxd;
  logic       loop = 1'b1, force_lvl = 1'b1;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic [8:0] exp_q[$];
  int cur_p = 2;

  assign rxd = loop ? txd : force_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_dual_rate uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_pre(cfg_pre),
    .cfg_tx_div(cfg_tx_div), .cfg_rx_div(cfg_rx_div),
    .cfg_tx_ext(cfg_tx_ext), .cfg_rx_ext(cfg_rx_ext),
    .tx_en(tx_en), .rx_en(rx_en), .word9(word9), .tx_wr(tx_wr),
    .tx_data(tx_data), .tx_bit8(tx_bit8), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_bit8(rx_bit8), .ie_txe(ie_txe), .ie_txc(ie_txc), .ie_rxf(ie_rxf),
    .ie_idle(ie_idle), .status(status), .irq(irq), .rxd(rxd), .txd(txd)
  );

  // independent rate model
  function automatic int model_period(int pre, int dv, int ext);
    int a;
    case (pre)
      0: a = 1;
      1: a = 3;
      2: a = 4;
      default: a = 13;
    endcase
    return 2 * a * (2 ** dv) * ((ext == 0) ? 1 : ext);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_rate(input int pre, input int dv, input int ext);
    @(negedge clk);
    cfg_pre = 2'(pre); cfg_tx_div = 3'(dv); cfg_rx_div = 3'(dv);
    cfg_tx_ext = 8'(ext); cfg_rx_ext = 8'(ext); cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic b8);
    int n = 0;
    while (!status[7] && n < 20000) begin @(negedge clk); n++; end
    tx_data = d; tx_bit8 = b8; tx_wr = 1'b1;
    exp_q.push_back({b8, d});
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic measure_start(output int len);
    int n = 0;
    len = 0;
    while (txd && n < 2000) begin @(negedge clk); n++; end
    while (!txd && len < 60000) begin @(negedge clk); len++; end
  endtask

  task automatic wait_rx(output bit got, input int limit);
    int n = 0;
    while (!status[5] && n < limit) begin @(negedge clk); n++; end
    got = status[5];
  endtask

  task automatic read_rx(output logic [7:0] d, output logic b8);
    d = rx_data; b8 = rx_bit8;
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic recv_cmp(input string req, input int limit);
    bit got;
    logic [7:0] d;
    logic b8;
    logic [8:0] e;
    wait_rx(got, limit);
    check(got, req, 0, 1);
    if (got) begin
      read_rx(d, b8);
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h1ff;
      check(d == e[7:0], req, d, e[7:0]);
      if (word9) check(b8 == e[8], req, b8, e[8]);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int len;
    bit got;
    logic [7:0] d;
    logic b8;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(status == 8'hC0, "R1 status", status, 8'hC0);
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(irq == 1'b0, "R1 irq", irq, 0);
    // R10 transmit-empty enable
    ie_txe = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R10 txe irq", irq, 1);
    ie_txe = 1'b0;

    // 8-bit, P = 2
    set_rate(0, 0, 0);
    cur_p = model_period(0, 0, 0);
    tx_en = 1'b1; rx_en = 1'b1;
    send(8'hA5, 1'b0);
    check(status[7] == 1'b0 && status[6] == 1'b0, "R4 write clears", status, 0);
    measure_start(len);
    check(len == 16 * cur_p, "R3 bit time P=2", len, 16 * cur_p);
    recv_cmp("R2 R6 8-bit A5", 2000);

    // R4 second write accepted, third ignored while full
    send(8'h3D, 1'b0);
    send(8'hC3, 1'b0);
    @(negedge clk);
    check(status[7] == 1'b0, "R4 buffer full", status[7], 0);
    tx_data = 8'h77; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    recv_cmp("R4 first queued", 2000);
    recv_cmp("R4 second queued", 2000);
    wait_rx(got, 1000);
    check(!got, "R4 ignored write", got, 0);
    check(status[6] == 1'b1, "R4 complete", status[6], 1);

    // R9 config write while enabled is ignored
    set_rate(3, 7, 255);
    send(8'h5B, 1'b0);
    measure_start(len);
    check(len == 16 * cur_p, "R9 rate unchanged", len, 16 * cur_p);
    recv_cmp("R9 data", 2000);

    // R8 idle and R11 clearing
    send(8'h81, 1'b0);
    wait_rx(got, 2000);
    read_rx(d, b8);
    void'(exp_q.pop_front());
    repeat (100) @(negedge clk);
    check(status[4] == 1'b0, "R8 not idle yet", status[4], 0);
    repeat (300) @(negedge clk);
    check(status[4] == 1'b1, "R8 idle set", status[4], 1);
    ie_idle = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R10 idle irq", irq, 1);
    ie_idle = 1'b0;
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    check(status[4] == 1'b0, "R11 idle cleared", status[4], 0);

    // R7 overrun
    send(8'h11, 1'b0);
    send(8'h22, 1'b0);
    while (!status[6]) @(negedge clk);
    repeat (20) @(negedge clk);
    check(status[3] == 1'b1, "R7 overrun", status[3], 1);
    check(rx_data == 8'h11, "R7 kept old", rx_data, 8'h11);
    ie_rxf = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R10 rxf irq", irq, 1);
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    check(status[5] == 1'b0 && status[3] == 1'b0, "R11 flags cleared", status, 0);
    check(irq == 1'b0, "R10 irq drops", irq, 0);
    ie_rxf = 1'b0;
    exp_q.delete();

    // R5 glitch rejection
    repeat (50) @(negedge clk);
    loop = 1'b0; force_lvl = 1'b0;
    repeat (4) @(negedge clk);
    force_lvl = 1'b1;
    wait_rx(got, 600);
    check(!got, "R5 glitch rejected", got, 0);
    loop = 1'b1;

    // 9-bit with extended divider, P = 6
    tx_en = 1'b0; rx_en = 1'b0;
    set_rate(0, 0, 3);
    cur_p = model_period(0, 0, 3);
    word9 = 1'b1;
    tx_en = 1'b1; rx_en = 1'b1;
    send(8'h3D, 1'b1);
    measure_start(len);
    check(len == 16 * cur_p, "R3 bit time ext=3", len, 16 * cur_p);
    recv_cmp("R2 R6 9-bit one", 3000);
    send(8'hE9, 1'b0);
    recv_cmp("R2 R6 9-bit zero", 3000);

    // 8-bit with coarse and divider codes, P = 12
    tx_en = 1'b0; rx_en = 1'b0;
    set_rate(1, 1, 0);
    cur_p = model_period(1, 1, 0);
    word9 = 1'b0;
    tx_en = 1'b1; rx_en = 1'b1;
    send(8'h6F, 1'b0);
    measure_start(len);
    check(len == 16 * cur_p, "R3 bit time pre=1 div=1", len, 16 * cur_p);
    recv_cmp("R6 at P=12", 4000);
    while (!status[6]) @(negedge clk);
    ie_txc = 1'b1;
    @(negedge clk);
    check(irq == 1'b1, "R10 txc irq", irq, 1);
    ie_txc = 1'b0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule